// File: doc/BRIEF.md
# Banked Processor Register File

This block is the architectural register store of a 32-bit CISC-style processor core. It keeps eight data registers, eight address registers, a second (inactive) stack pointer, five condition flags and a status word. The status word holds an interrupt mask, a supervisor bit and a trace bit. Reads are combinational. Writes take effect on the rising clock edge. There is one write port for data registers and one for address registers, and both may be used in the same cycle.

Every register access carries a size code. A data-register write merges only the sized low part into the register, and a data-register read returns the sized part with zeros above it. Address registers always hold full 32-bit values: writes are sign-extended before they are stored, and reads sign-extend the sized low part.

Address register 7 is the active stack pointer. When a status-word write flips the supervisor bit, the active pointer and the inactive pointer exchange contents. After reset the core is in supervisor mode, so the inactive pointer then holds the user stack pointer.

Top module: `cpu_regbank`

## Requirements
- R1: A data-register write of byte size (size code 0) replaces bits 7:0 and keeps bits 31:8. A word write (code 1) replaces bits 15:0 and keeps bits 31:16. A long write (code 2 or 3) replaces all 32 bits.
- R2: A data-register read (class bit 0) returns bits 7:0, 15:0 or 31:0 for size codes 0, 1 and 2/3, with zeros above, in the same cycle as the request.
- R3: An address-register write sign-extends the sized data to 32 bits: bit 7 for a byte, bit 15 for a word.
- R4: An address-register read (class bit 1) returns the sized low part of the register, sign-extended to 32 bits.
- R5: The condition byte reads as carry in bit 0, overflow in bit 1, zero in bit 2, negative in bit 3, extend in bit 4, and zeros in bits 7:5.
- R6: The status word reads as the condition byte in bits 7:0, the interrupt mask in bits 10:8, supervisor in bit 13 and trace in bit 15. Bits 12:11 and 14 always read 0, whatever value was written.
- R7: A condition-byte write changes only the five flags. The mask, supervisor and trace bits keep their values.
- R8: A status-word write that changes bit 13 exchanges address register 7 with the inactive stack pointer. A status-word write that keeps bit 13 exchanges nothing.
- R9: If an address write to register 7 happens in the same cycle as a swapping status write, the exchange happens first. The written value lands in the newly active pointer, and the old active value moves to the inactive pointer.
- R10: After a synchronous active-low reset, every register, pointer and flag is zero, supervisor is 1, the mask is 7 and trace is 0. The status word reads 0x2700.
- R11: If the condition-byte write and the status-word write are both asserted in one cycle, the status-word value sets the flags and the condition-byte value is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| dwr_en | input | 1 | Data-register write enable |
| dwr_idx | input | 3 | Data-register write index |
| dwr_size | input | 2 | Data write size (0 byte, 1 word, 2/3 long) |
| dwr_data | input | 32 | Data write value |
| awr_en | input | 1 | Address-register write enable |
| awr_idx | input | 3 | Address-register write index |
| awr_size | input | 2 | Address write size |
| awr_data | input | 32 | Address write value |
| rd_cls | input | 2 | Per read port: 0 data, 1 address |
| rd_idx | input | 6 | Per read port register index, 3 bits each |
| rd_size | input | 4 | Per read port size code, 2 bits each |
| rd_data | output | 64 | Per read port result, 32 bits each |
| ccr_we | input | 1 | Condition-byte write enable |
| ccr_wdata | input | 8 | Condition-byte write value |
| sr_we | input | 1 | Status-word write enable |
| sr_wdata | input | 16 | Status-word write value |
| ccr_rdata | output | 8 | Condition byte |
| sr_rdata | output | 16 | Status word |

## Verification
The assertions assume that reset is held low for at least one edge before any write is checked. They also assume that index and size inputs are known whenever their enable is high. The stack-exchange property checks only cycles in which no address write targets register 7. It leaves the same-cycle collision of R9 to the bench. The bench drives every enable and field from a seeded `$urandom`, so all values stay known. It keeps status writes infrequent, so long stretches run in both supervisor and user mode. Directed cases cover the merge boundaries, the sign bits, the swap collision and the double flag write.

// File: rtl/regbank_pkg.sv
// Package: shared widths, size codes and sizing helpers for the register bank.
// Assumes a size code of 3 behaves as long.
package regbank_pkg;
    parameter int XLEN = 32;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_WORD = 2'd1,
        SZ_LONG = 2'd2,
        SZ_ALT  = 2'd3
    } opsize_e;

    // Mask that covers the sized low part of a word.
    function automatic logic [XLEN-1:0] size_mask(input logic [1:0] sz);
        case (sz)
            SZ_BYTE: size_mask = {{(XLEN-8){1'b0}}, 8'hFF};
            SZ_WORD: size_mask = {{(XLEN-16){1'b0}}, 16'hFFFF};
            default: size_mask = {XLEN{1'b1}};
        endcase
    endfunction

    // Sign-extend the sized low part of a word to the full width.
    function automatic logic [XLEN-1:0] sext_size(input logic [XLEN-1:0] v, input logic [1:0] sz);
        case (sz)
            SZ_BYTE: sext_size = {{(XLEN-8){v[7]}}, v[7:0]};
            SZ_WORD: sext_size = {{(XLEN-16){v[15]}}, v[15:0]};
            default: sext_size = v;
        endcase
    endfunction
endpackage

// File: rtl/regbank_data.sv
// Data register array. A sized write merges into the low part and keeps the
// upper bits. Assumes idx and size are known while wr_en is high.
module regbank_data
    import regbank_pkg::*;
#(
    parameter int NREG = 8,
    localparam int IW = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [IW-1:0]   wr_idx,
    input  logic [1:0]      wr_size,
    input  logic [XLEN-1:0] wr_data,
    output logic [XLEN-1:0] regs_o [NREG]
);
    logic [XLEN-1:0] d_q [NREG];
    logic [XLEN-1:0] wmask;

    // Select which bits the write replaces.
    always_comb wmask = size_mask(wr_size);

    // Store the merged write and clear everything on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) d_q[i] <= '0;
        end else if (wr_en) begin
            d_q[wr_idx] <= (d_q[wr_idx] & ~wmask) | (wr_data & wmask);
        end
    end

    assign regs_o = d_q;

    generate
        for (genvar g = 0; g < NREG; g++) begin : g_chk
            // R1: a byte write keeps the upper bits of its target.
            p_byte_keep_r1: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_en && wr_idx == IW'(g) && wr_size == SZ_BYTE)
                |=> d_q[g][XLEN-1:8] == $past(d_q[g][XLEN-1:8]));
            // R1: a word write keeps the upper half of its target.
            p_word_keep_r1: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_en && wr_idx == IW'(g) && wr_size == SZ_WORD)
                |=> d_q[g][XLEN-1:16] == $past(d_q[g][XLEN-1:16]));
        end
    endgenerate
endmodule

// File: rtl/regbank_addr.sv
// Address register array and inactive stack pointer. Writes are sign-extended.
// A swap request exchanges the top register and the inactive pointer before
// the write of that cycle is applied. Assumes known inputs while enabled.
module regbank_addr
    import regbank_pkg::*;
#(
    parameter int NREG = 8,
    localparam int IW = $clog2(NREG),
    localparam int SPI = NREG - 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [IW-1:0]   wr_idx,
    input  logic [1:0]      wr_size,
    input  logic [XLEN-1:0] wr_data,
    input  logic            swap,
    output logic [XLEN-1:0] regs_o [NREG]
);
    logic [XLEN-1:0] a_q [NREG];
    logic [XLEN-1:0] sp_q;
    logic [XLEN-1:0] wval;
    logic            wr_sp;

    // Extend the write value and flag a write to the stack pointer.
    always_comb begin
        wval  = sext_size(wr_data, wr_size);
        wr_sp = wr_en && (wr_idx == IW'(SPI));
    end

    // Update the registers: exchange first, then the write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) a_q[i] <= '0;
            sp_q <= '0;
        end else begin
            if (swap) sp_q <= a_q[SPI];
            if (wr_sp)      a_q[SPI] <= wval;
            else if (swap)  a_q[SPI] <= sp_q;
            if (wr_en && !wr_sp) a_q[wr_idx] <= wval;
        end
    end

    assign regs_o = a_q;

    // R8: an exchange without a colliding write moves both pointers.
    p_sp_swap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (swap && !wr_sp) |=> (a_q[SPI] == $past(sp_q)) && (sp_q == $past(a_q[SPI])));
    // R9: with a collision, the old active pointer goes to the inactive slot.
    p_sp_collide_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (swap && wr_sp) |=> sp_q == $past(a_q[SPI]));
    // R8: without an exchange the inactive pointer holds its value.
    p_sp_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !swap |=> $stable(sp_q));

    generate
        for (genvar g = 0; g < NREG; g++) begin : g_chk
            // R3: a byte write leaves the register sign-extended from bit 7.
            p_byte_sext_r3: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_en && wr_idx == IW'(g) && wr_size == SZ_BYTE)
                |=> a_q[g][XLEN-1:8] == {(XLEN-8){a_q[g][7]}});
        end
    endgenerate
endmodule

// File: rtl/regbank_status.sv
// Condition flags and status fields. A status write takes priority over a
// flag write in the same cycle. Emits a swap request when the supervisor bit
// is about to change.
module regbank_status #(
    parameter int MASKW = 3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ccr_we,
    input  logic [7:0]  ccr_wdata,
    input  logic        sr_we,
    input  logic [15:0] sr_wdata,
    output logic [7:0]  ccr_rdata,
    output logic [15:0] sr_rdata,
    output logic        swap
);
    logic [4:0]       flags_q;   // {x, n, z, v, c}
    logic [MASKW-1:0] imask_q;
    logic             sup_q;
    logic             trc_q;

    // Request a pointer exchange when the supervisor bit flips.
    always_comb swap = sr_we && (sr_wdata[13] != sup_q);

    // Hold the status fields; the status write wins over the flag write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= '0;
            imask_q <= '1;
            sup_q   <= 1'b1;
            trc_q   <= 1'b0;
        end else if (sr_we) begin
            flags_q <= sr_wdata[4:0];
            imask_q <= sr_wdata[8 +: MASKW];
            sup_q   <= sr_wdata[13];
            trc_q   <= sr_wdata[15];
        end else if (ccr_we) begin
            flags_q <= ccr_wdata[4:0];
        end
    end

    // Pack the read views; unimplemented bits are zero.
    always_comb begin
        ccr_rdata = {3'b000, flags_q};
        sr_rdata  = '0;
        sr_rdata[7:0]          = ccr_rdata;
        sr_rdata[8 +: MASKW]   = imask_q;
        sr_rdata[13]           = sup_q;
        sr_rdata[15]           = trc_q;
    end

    // R7: a lone flag write keeps the mask, supervisor and trace bits.
    p_ccr_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ccr_we && !sr_we) |=> $stable(sr_rdata[15:8]));
    // R10: reset leaves supervisor set, mask at 7 and the flags clear.
    p_reset_state_r10: assert property (@(posedge clk)
        !rst_n |=> sr_rdata == 16'h2700);
    // R11: with both writes, the flags follow the status value.
    p_sr_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (ccr_we && sr_we) |=> ccr_rdata[4:0] == $past(sr_wdata[4:0]));
endmodule

// File: rtl/cpu_regbank.sv
// Top of the banked register file: data array, address array with the
// inactive stack pointer, status fields and NRD combinational read ports.
// Assumes read selects are known whenever the result is used.
module cpu_regbank
    import regbank_pkg::*;
#(
    parameter int NREG = 8,
    parameter int NRD  = 2,
    localparam int IW  = $clog2(NREG)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                dwr_en,
    input  logic [IW-1:0]       dwr_idx,
    input  logic [1:0]          dwr_size,
    input  logic [XLEN-1:0]     dwr_data,
    input  logic                awr_en,
    input  logic [IW-1:0]       awr_idx,
    input  logic [1:0]          awr_size,
    input  logic [XLEN-1:0]     awr_data,
    input  logic [NRD-1:0]      rd_cls,
    input  logic [NRD*IW-1:0]   rd_idx,
    input  logic [NRD*2-1:0]    rd_size,
    output logic [NRD*XLEN-1:0] rd_data,
    input  logic                ccr_we,
    input  logic [7:0]          ccr_wdata,
    input  logic                sr_we,
    input  logic [15:0]         sr_wdata,
    output logic [7:0]          ccr_rdata,
    output logic [15:0]         sr_rdata
);
    logic [XLEN-1:0] dregs [NREG];
    logic [XLEN-1:0] aregs [NREG];
    logic            swap;

    regbank_data #(.NREG(NREG)) u_data (
        .clk(clk), .rst_n(rst_n),
        .wr_en(dwr_en), .wr_idx(dwr_idx), .wr_size(dwr_size), .wr_data(dwr_data),
        .regs_o(dregs)
    );

    regbank_addr #(.NREG(NREG)) u_addr (
        .clk(clk), .rst_n(rst_n),
        .wr_en(awr_en), .wr_idx(awr_idx), .wr_size(awr_size), .wr_data(awr_data),
        .swap(swap), .regs_o(aregs)
    );

    regbank_status u_status (
        .clk(clk), .rst_n(rst_n),
        .ccr_we(ccr_we), .ccr_wdata(ccr_wdata),
        .sr_we(sr_we), .sr_wdata(sr_wdata),
        .ccr_rdata(ccr_rdata), .sr_rdata(sr_rdata), .swap(swap)
    );

    generate
        for (genvar r = 0; r < NRD; r++) begin : g_rd
            logic [IW-1:0] ridx;
            logic [1:0]    rsz;
            assign ridx = rd_idx[r*IW +: IW];
            assign rsz  = rd_size[r*2 +: 2];
            // Size the selected register: zero-fill for data, sign for address.
            always_comb begin
                if (rd_cls[r]) rd_data[r*XLEN +: XLEN] = sext_size(aregs[ridx], rsz);
                else           rd_data[r*XLEN +: XLEN] = dregs[ridx] & size_mask(rsz);
            end
            // R2: a data read of byte size has nothing above bit 7.
            p_dread_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
                (!rd_cls[r] && rsz == SZ_BYTE) |-> rd_data[r*XLEN+8 +: XLEN-8] == '0);
            // R4: an address read of word size is sign-extended from bit 15.
            p_aread_sext_r4: assert property (@(posedge clk) disable iff (!rst_n)
                (rd_cls[r] && rsz == SZ_WORD)
                |-> rd_data[r*XLEN+16 +: XLEN-16] == {(XLEN-16){rd_data[r*XLEN+15]}});
        end
    endgenerate

    // R6: unimplemented status bits never read as one.
    p_sr_unused_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sr_rdata[7:5] == 3'b000) && (sr_rdata[12:11] == 2'b00) && !sr_rdata[14]);
endmodule

// File: tb/tb_cpu_regbank.sv
module tb_cpu_regbank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dwr_en = 0, awr_en = 0, ccr_we = 0, sr_we = 0;
    logic [2:0]  dwr_idx = 0, awr_idx = 0;
    logic [1:0]  dwr_size = 0, awr_size = 0;
    logic [31:0] dwr_data = 0, awr_data = 0;
    logic [1:0]  rd_cls = 0;
    logic [5:0]  rd_idx = 0;
    logic [3:0]  rd_size = 0;
    logic [63:0] rd_data;
    logic [7:0]  ccr_wdata = 0, ccr_rdata;
    logic [15:0] sr_wdata = 0, sr_rdata;

    int tests = 0, fails = 0;
    bit done = 0;

    // Reference state.
    logic [31:0] md [8];
    logic [31:0] ma [8];
    logic [31:0] msp;
    logic [4:0]  mfl;
    logic [2:0]  mim;
    logic        ms, mt;

    always #10 clk = ~clk;

    cpu_regbank dut (.*);

    function automatic logic [31:0] mk(input logic [1:0] sz);
        return (sz == 2'd0) ? 32'hFF : (sz == 2'd1) ? 32'hFFFF : 32'hFFFF_FFFF;
    endfunction
    function automatic logic [31:0] sx(input logic [31:0] v, input logic [1:0] sz);
        if (sz == 2'd0) return {{24{v[7]}}, v[7:0]};
        if (sz == 2'd1) return {{16{v[15]}}, v[15:0]};
        return v;
    endfunction
    function automatic logic [31:0] exp_rd(input logic c, input logic [2:0] i, input logic [1:0] sz);
        return c ? sx(ma[i], sz) : (md[i] & mk(sz));
    endfunction
    function automatic logic [15:0] exp_sr();
        return {mt, 1'b0, ms, 2'b00, mim, 3'b000, mfl};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 8; i++) begin md[i] = 0; ma[i] = 0; end
        msp = 0; mfl = 0; mim = 3'd7; ms = 1; mt = 0;
    endtask

    // Check read ports and status before the edge, then advance the model.
    task automatic cycle();
        logic sw;
        #2;
        chk(rd_cls[0] ? "R4 port0" : "R2 port0", rd_data[31:0],  exp_rd(rd_cls[0], rd_idx[2:0], rd_size[1:0]));
        chk(rd_cls[1] ? "R4 port1" : "R2 port1", rd_data[63:32], exp_rd(rd_cls[1], rd_idx[5:3], rd_size[3:2]));
        chk("R5 ccr", {24'd0, ccr_rdata}, {27'd0, mfl});
        chk("R6 sr", {16'd0, sr_rdata}, {16'd0, exp_sr()});
        @(posedge clk);
        sw = sr_we && (sr_wdata[13] != ms);
        if (sr_we) begin
            mfl = sr_wdata[4:0]; mim = sr_wdata[10:8]; ms = sr_wdata[13]; mt = sr_wdata[15];
        end else if (ccr_we) mfl = ccr_wdata[4:0];
        if (dwr_en) md[dwr_idx] = (md[dwr_idx] & ~mk(dwr_size)) | (dwr_data & mk(dwr_size));
        if (sw) begin logic [31:0] t; t = ma[7]; ma[7] = msp; msp = t; end
        if (awr_en) ma[awr_idx] = sx(awr_data, awr_size);
        @(negedge clk);
    endtask

    task automatic idle();
        dwr_en = 0; awr_en = 0; ccr_we = 0; sr_we = 0;
    endtask

    task automatic rd0(input logic c, input logic [2:0] i, input logic [1:0] sz);
        rd_cls[0] = c; rd_idx[2:0] = i; rd_size[1:0] = sz; #1;
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            fails++; tests++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        model_reset();
        rst_n = 0;
        @(negedge clk); @(negedge clk);
        rst_n = 1;
        // R10: reset state.
        #1;
        chk("R10 sr after reset", {16'd0, sr_rdata}, 32'h2700);
        rd0(1, 3'd7, 2'd2);
        chk("R10 a7 after reset", rd_data[31:0], 32'h0);

        // R1: byte and word merges into a data register.
        idle(); dwr_en = 1; dwr_idx = 3; dwr_size = 2; dwr_data = 32'h1234_5678; cycle();
        dwr_size = 0; dwr_data = 32'hFFFF_FFAB; cycle();
        idle(); rd0(0, 3'd3, 2'd2);
        chk("R1 byte merge", rd_data[31:0], 32'h1234_56AB);
        dwr_en = 1; dwr_size = 1; dwr_data = 32'hAAAA_BEEF; cycle(); idle();
        rd0(0, 3'd3, 2'd2);
        chk("R1 word merge", rd_data[31:0], 32'h1234_BEEF);
        rd0(0, 3'd3, 2'd0);
        chk("R2 byte read zero-fill", rd_data[31:0], 32'h0000_00EF);

        // R3 / R4: address sign extension.
        awr_en = 1; awr_idx = 2; awr_size = 0; awr_data = 32'h0000_0080; cycle(); idle();
        rd0(1, 3'd2, 2'd2);
        chk("R3 byte sext", rd_data[31:0], 32'hFFFF_FF80);
        awr_en = 1; awr_idx = 2; awr_size = 2; awr_data = 32'h0001_7FFF; cycle(); idle();
        rd0(1, 3'd2, 2'd0);
        chk("R4 byte read sext", rd_data[31:0], 32'hFFFF_FFFF);
        rd0(1, 3'd2, 2'd1);
        chk("R4 word read sext", rd_data[31:0], 32'h0000_7FFF);

        // R7: a flag write keeps the upper fields; R6: unused bits stay 0.
        sr_we = 1; sr_wdata = 16'hFF00; cycle(); idle();
        ccr_we = 1; ccr_wdata = 8'hFF; cycle(); idle(); #1;
        chk("R7 ccr write keeps upper", {16'd0, sr_rdata}, 32'hA71F);
        chk("R5 ccr layout", {24'd0, ccr_rdata}, 32'h1F);
        // R11: status value beats flag value.
        sr_we = 1; sr_wdata = 16'h2705; ccr_we = 1; ccr_wdata = 8'h1A; cycle(); idle(); #1;
        chk("R11 sr wins over ccr", {24'd0, ccr_rdata}, 32'h05);

        // R8: swap on supervisor change, none otherwise.
        awr_en = 1; awr_idx = 7; awr_size = 2; awr_data = 32'h0000_1000; cycle(); idle();
        sr_we = 1; sr_wdata = 16'h0000; cycle(); idle();
        rd0(1, 3'd7, 2'd2);
        chk("R8 swap to user", rd_data[31:0], 32'h0);
        sr_we = 1; sr_wdata = 16'h0001; cycle(); idle();
        rd0(1, 3'd7, 2'd2);
        chk("R8 no swap same bit", rd_data[31:0], 32'h0);
        sr_we = 1; sr_wdata = 16'h2000; cycle(); idle();
        rd0(1, 3'd7, 2'd2);
        chk("R8 swap back", rd_data[31:0], 32'h0000_1000);

        // R9: swap and write to register 7 in one cycle.
        sr_we = 1; sr_wdata = 16'h0000;
        awr_en = 1; awr_idx = 7; awr_size = 2; awr_data = 32'h5555_5555; cycle(); idle();
        rd0(1, 3'd7, 2'd2);
        chk("R9 write lands in new pointer", rd_data[31:0], 32'h5555_5555);
        sr_we = 1; sr_wdata = 16'h2000; cycle(); idle();
        rd0(1, 3'd7, 2'd2);
        chk("R9 old pointer preserved", rd_data[31:0], 32'h0000_1000);

        // Random mix checked against the model.
        for (int n = 0; n < 3000; n++) begin
            dwr_en = $urandom_range(0, 1); dwr_idx = 3'($urandom); dwr_size = 2'($urandom); dwr_data = $urandom;
            awr_en = $urandom_range(0, 1); awr_idx = 3'($urandom); awr_size = 2'($urandom); awr_data = $urandom;
            ccr_we = ($urandom_range(0, 3) == 0); ccr_wdata = 8'($urandom);
            sr_we = ($urandom_range(0, 15) == 0); sr_wdata = 16'($urandom);
            rd_cls = 2'($urandom); rd_idx = 6'($urandom); rd_size = 4'($urandom);
            cycle();
        end

        // R10: reset mid-run restores the initial state.
        idle(); rst_n = 0; @(negedge clk); rst_n = 1; model_reset(); #1;
        chk("R10 sr after late reset", {16'd0, sr_rdata}, 32'h2700);
        rd0(0, 3'd3, 2'd2);
        chk("R10 data cleared", rd_data[31:0], 32'h0);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule